// File: doc/BRIEF.md
# Base-Index-Displacement Address Generator

This block forms operand addresses and operand values for an execution unit. It holds a file of sixteen 32-bit general registers with one write port. A request names a mode, two register fields and a 12-bit constant field, and one clock later the block presents a registered result together with a valid flag.

In address mode the result is a 24-bit effective address. The block adds the low 24 bits of the base register, the low 24 bits of the index register and the unsigned displacement, and it drops any carry out of bit 23. A register field of 0 adds nothing: register 0 can hold data, but it never takes part in an address sum. In immediate mode the low byte of the constant field is returned, zero-extended. In register mode the full 32-bit content of the register named by the base field is returned.

A small controller with two states, `ST_IDLE` and `ST_PRESENT`, sequences the output. A request strobe moves it from `ST_IDLE` to `ST_PRESENT` (transition "accept"). A further strobe while it is in `ST_PRESENT` keeps it there (transition "chain"). A cycle with no strobe returns it to `ST_IDLE` (transition "drain"). Reset places it in `ST_IDLE`.

Top module: `eff_addr_unit`

## Requirements
- R1: After reset `res_valid` is 0, `res_value` is 0 and all sixteen registers read as 0.
- R2: When `wr_en` is 1 at a rising clock edge, the register named by `wr_sel` takes `wr_data`, and later reads return that value.
- R3: In mode 2'b00 (address), `res_value[23:0]` equals base[23:0] + index[23:0] + `req_disp`, and `res_value[31:8+16]` (bits 31:24) is 0.
- R4: In address mode a base or index field of 0 adds zero, whatever register 0 holds.
- R5: The address sum wraps modulo 2^24. Register bits 31:24 never affect the address.
- R6: In mode 2'b01 (immediate), `res_value` is `req_disp[7:0]` zero-extended. `req_disp[11:8]` is ignored.
- R7: In mode 2'b10 (register), `res_value` is the full 32-bit content of the register named by `req_base`, including register 0.
- R8: `res_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1. Back-to-back requests give back-to-back results.
- R9: While `req_valid` is 0, `res_value` holds its last value.
- R10: A request in the same cycle as a write to the register it reads sees the old content. The write is not forwarded.
- R11: In mode 2'b11 (reserved), `res_value` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 4 | Register number to write |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 2 | 00 address, 01 immediate, 10 register, 11 reserved |
| req_base | input | 4 | Base register field (selected register in register mode) |
| req_index | input | 4 | Index register field |
| req_disp | input | 12 | Displacement; low byte is the immediate |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_value | output | 32 | Registered address or operand value |

## Verification
The assertions assume that `req_mode`, `req_disp`, `req_base` and `req_index` are stable and known whenever `req_valid` is high. They also assume that reset is applied before the first request. The bench changes every input only on the falling clock edge and holds it for a full cycle. Each request therefore lands in exactly one rising edge. The bench uses its own shadow copy of the register writes to predict every expected value, and it issues a request in the same cycle as a write only in the deliberate no-forwarding scenario.

// File: rtl/eag_pkg.sv
package eag_pkg;
    typedef enum logic [1:0] {
        MODE_ADDR = 2'b00,
        MODE_IMM  = 2'b01,
        MODE_REG  = 2'b10,
        MODE_RSVD = 2'b11
    } mode_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } state_e;
endpackage

// File: rtl/eag_regfile.sv
module eag_regfile #(
    parameter int DATA_W = 32,
    parameter int NREG   = 16,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  rsel_a,
    input  logic [SEL_W-1:0]  rsel_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] gpr [NREG];

    // One register per entry; only the selected entry loads.
    for (genvar g = 0; g < NREG; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                gpr[g] <= '0;
            else if (we && (wsel == SEL_W'(g)))
                gpr[g] <= wdata;
        end
    end

    // Reads see the contents before this edge's write.
    assign rdata_a = gpr[rsel_a];
    assign rdata_b = gpr[rsel_b];
endmodule

// File: rtl/eag_sum.sv
module eag_sum #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 24,
    parameter int SEL_W  = 4,
    parameter int DISP_W = 12
) (
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] index_val,
    input  logic [SEL_W-1:0]  base_sel,
    input  logic [SEL_W-1:0]  index_sel,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] base_term;
    logic [ADDR_W-1:0] index_term;

    // A field of zero selects no register at all.
    assign base_term  = (base_sel  == '0) ? '0 : base_val[ADDR_W-1:0];
    assign index_term = (index_sel == '0) ? '0 : index_val[ADDR_W-1:0];

    // Carries past ADDR_W are dropped by the result width.
    assign addr = base_term + index_term + ADDR_W'(disp);
endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl
    import eag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 24,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] reg_val,
    output logic              valid,
    output logic [DATA_W-1:0] value
);
    state_e            state_q, state_d;
    logic [DATA_W-1:0] pick;

    always_comb begin
        unique case (state_q)
            ST_IDLE:    state_d = strobe ? ST_PRESENT : ST_IDLE;   // accept
            ST_PRESENT: state_d = strobe ? ST_PRESENT : ST_IDLE;   // chain / drain
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (mode)
            MODE_ADDR: pick = DATA_W'(addr);
            MODE_IMM:  pick = DATA_W'(imm);
            MODE_REG:  pick = reg_val;
            MODE_RSVD: pick = '0;
            default:   pick = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      value <= '0;
        else if (strobe) value <= pick;
    end

    assign valid = (state_q == ST_PRESENT);
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
    import eag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 24,
    parameter int NREG   = 16,
    parameter int DISP_W = 12,
    parameter int IMM_W  = 8,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              req_valid,
    input  logic [1:0]        req_mode,
    input  logic [SEL_W-1:0]  req_base,
    input  logic [SEL_W-1:0]  req_index,
    input  logic [DISP_W-1:0] req_disp,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_value
);
    logic [DATA_W-1:0] base_val;
    logic [DATA_W-1:0] index_val;
    logic [ADDR_W-1:0] ea;

    eag_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .wsel    (wr_sel),
        .wdata   (wr_data),
        .rsel_a  (req_base),
        .rsel_b  (req_index),
        .rdata_a (base_val),
        .rdata_b (index_val)
    );

    eag_sum #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .DISP_W(DISP_W)) u_sum (
        .base_val  (base_val),
        .index_val (index_val),
        .base_sel  (req_base),
        .index_sel (req_index),
        .disp      (req_disp),
        .addr      (ea)
    );

    eag_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (req_valid),
        .mode    (mode_e'(req_mode)),
        .addr    (ea),
        .imm     (req_disp[IMM_W-1:0]),
        .reg_val (base_val),
        .valid   (res_valid),
        .value   (res_value)
    );
endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 24,
    parameter int SEL_W  = 4,
    parameter int DISP_W = 12,
    parameter int IMM_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_mode,
    input logic [SEL_W-1:0]  req_base,
    input logic [SEL_W-1:0]  req_index,
    input logic [DISP_W-1:0] req_disp,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_value
);
    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    p_no_spurious_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    p_hold_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(res_value));

    p_addr_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b00) |=> (res_value[DATA_W-1:ADDR_W] == '0));

    p_imm_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b01) |=>
            (res_value == DATA_W'($past(req_disp[IMM_W-1:0]))));

    p_zero_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b00 && req_base == '0 && req_index == '0) |=>
            (res_value == DATA_W'($past(req_disp))));

    p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b11) |=> (res_value == '0));
endmodule

bind eff_addr_unit eag_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .DISP_W(DISP_W), .IMM_W(IMM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .req_base  (req_base),
    .req_index (req_index),
    .req_disp  (req_disp),
    .res_valid (res_valid),
    .res_value (res_value)
);

// File: tb/eff_addr_unit_tb.sv
module eff_addr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mode = '0;
    logic [3:0]  req_base = '0;
    logic [3:0]  req_index = '0;
    logic [11:0] req_disp = '0;
    logic        res_valid;
    logic [31:0] res_value;

    int checks = 0;
    int errors = 0;
    logic [31:0] shadow [16];

    always #5 clk = ~clk;

    eff_addr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .req_valid(req_valid), .req_mode(req_mode), .req_base(req_base),
        .req_index(req_index), .req_disp(req_disp),
        .res_valid(res_valid), .res_value(res_value)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_ea(input logic [3:0] b, input logic [3:0] x,
                                             input logic [11:0] d);
        logic [23:0] s;
        s = ((b == 0) ? 24'd0 : shadow[b][23:0]) + ((x == 0) ? 24'd0 : shadow[x][23:0]) + 24'(d);
        return {8'd0, s};
    endfunction

    task automatic write_reg(input logic [3:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        shadow[sel] = data;
    endtask

    // Issue one request; check result in the cycle after, and valid drop one later.
    task automatic request(input string tag, input logic [1:0] m, input logic [3:0] b,
                           input logic [3:0] x, input logic [11:0] d, input logic [31:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_base = b; req_index = x; req_disp = d;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, 32'(res_valid), 32'd1);
        check(tag, res_value, exp);
        @(negedge clk);
        check("R8 valid drop", 32'(res_valid), 32'd0);
    endtask

    task automatic t_reset();
        check("R1 valid", 32'(res_valid), 32'd0);
        check("R1 value", res_value, 32'd0);
        request("R1 reg3 zero", 2'b10, 4'd3, 4'd0, 12'h0, 32'd0);
    endtask

    task automatic t_basic();
        write_reg(4'd1, 32'h0000_0100);
        write_reg(4'd2, 32'h0000_0020);
        request("R2 R3 sum", 2'b00, 4'd1, 4'd2, 12'h005, 32'h0000_0125);
        request("R3 sum", 2'b00, 4'd2, 4'd1, 12'h7FF, model_ea(4'd2, 4'd1, 12'h7FF));
    endtask

    task automatic t_zero_field();
        write_reg(4'd0, 32'h00AB_CDEF);
        request("R4 base0", 2'b00, 4'd0, 4'd2, 12'h007, 32'h0000_0027);
        request("R4 index0", 2'b00, 4'd1, 4'd0, 12'h000, 32'h0000_0100);
        request("R7 reg0 direct", 2'b10, 4'd0, 4'd0, 12'h000, 32'h00AB_CDEF);
    endtask

    task automatic t_wrap();
        write_reg(4'd14, 32'hFFFF_FFFF);
        write_reg(4'd15, 32'hFFFF_FFFF);
        request("R5 wrap", 2'b00, 4'd14, 4'd15, 12'hFFF, 32'h0000_0FFD);
        write_reg(4'd3, 32'hAB00_0010);
        request("R5 upper ignored", 2'b00, 4'd3, 4'd0, 12'h000, 32'h0000_0010);
    endtask

    task automatic t_imm_reg();
        request("R6 imm", 2'b01, 4'd14, 4'd15, 12'hF5A, 32'h0000_005A);
        request("R7 direct", 2'b10, 4'd14, 4'd1, 12'h123, 32'hFFFF_FFFF);
        request("R11 reserved", 2'b11, 4'd14, 4'd15, 12'hFFF, 32'd0);
    endtask

    task automatic t_chain_hold();
        @(negedge clk);
        req_valid = 1'b1; req_mode = 2'b01; req_disp = 12'h011;
        @(negedge clk);
        check("R8 chain valid A", 32'(res_valid), 32'd1);
        check("R8 chain value A", res_value, 32'h11);
        req_mode = 2'b00; req_base = 4'd1; req_index = 4'd2; req_disp = 12'h001;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 chain valid B", 32'(res_valid), 32'd1);
        check("R8 chain value B", res_value, 32'h121);
        req_mode = 2'b01; req_disp = 12'hFFF;
        @(negedge clk);
        @(negedge clk);
        check("R9 hold", res_value, 32'h121);
        check("R8 idle", 32'(res_valid), 32'd0);
    endtask

    task automatic t_no_forward();
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 4'd5; wr_data = 32'hDEAD_BEEF;
        req_valid = 1'b1; req_mode = 2'b10; req_base = 4'd5;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R10 old value", res_value, 32'd0);
        shadow[5] = 32'hDEAD_BEEF;
        request("R10 new value", 2'b10, 4'd5, 4'd0, 12'h0, 32'hDEAD_BEEF);
    endtask

    initial begin
        for (int k = 0; k < 16; k++) shadow[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero_field();
        t_wrap();
        t_imm_reg();
        t_chain_hold();
        t_no_forward();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule